// File: doc/BRIEF.md
# Three-Leg Turn-On Delay Generator

This block sits between a modulator and the gate drivers of a three-phase bridge. Each leg receives one logic-level switching command. The block turns that command into a complementary pair of gate signals, one for the high side and one for the low side. A gate is switched on only after the command has stayed at the new level for a fixed number of clock cycles. A gate is switched off as soon as the command leaves its level. Both switches of a leg are therefore off for the programmed interval at every transition. The interval is a count of block clocks, so it is set by choosing the clock frequency.

The command enters through a two-stage synchronizer, so it may be asynchronous to the block clock. An enable input shuts all six gates at once. A separate enable for each gate shuts that gate alone. Both enables act combinationally, without waiting for a clock. A parameter selects active-high or active-low gate outputs.

Top module: `tri_leg_deadtime`

## Requirements
- R1: While reset is asserted, and directly after it, both gates of every leg are inactive. With the command held low and all enables high, the low-side gate turns on after the 8th rising clock edge following reset release.
- R2: After a command rise, the high-side gate turns on after the 10th rising clock edge, counting the edge that first samples the command high as the 1st edge. This holds only if the command stays high through all of those samples.
- R3: After a command fall, the low-side gate turns on after the 10th rising clock edge, counting the edge that first samples the command low as the 1st edge. This holds only if the command stays low through all of those samples.
- R4: A gate that is on turns off after the 2nd rising edge that samples the opposite command level, which is the synchronizer latency alone. No turn-on delay is added to a turn-off.
- R5: If the command returns to its previous level before the count finishes, the pending turn-on is dropped. The count restarts for the opposite gate, so a pulse shorter than 9 samples never turns on a gate.
- R6: When the global enable is low, all six gates are inactive in the same cycle, without a clock edge.
- R7: Each gate has its own enable bit: bit i of the high enable belongs to the high-side gate of leg i, and bit i of the low enable belongs to the low-side gate of leg i. A low bit forces only that gate inactive, and the other gates are unaffected.
- R8: The high-side and low-side gates of one leg are never active in the same cycle.
- R9: The three legs are timed independently. The command of one leg has no effect on the gates of another leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; one period is one delay unit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | NUM_LEGS | Switching command per leg (1 = high side conducts) |
| en_all_i | input | 1 | Global gate enable, active high |
| en_hi_i | input | NUM_LEGS | Per-leg high-side gate enable |
| en_lo_i | input | NUM_LEGS | Per-leg low-side gate enable |
| gate_hi_o | output | NUM_LEGS | High-side gate drive per leg |
| gate_lo_o | output | NUM_LEGS | Low-side gate drive per leg |

## Verification
The hardest case to reach is a command that reverses while a turn-on count is running. The count must be dropped, and a fresh count must start for the opposite gate, without either gate ever turning on. Directed pulses of a few cycles create this case on purpose. The random phase then draws hold times between one and twenty cycles on every leg, so reversals land at every count value. Every cycle is compared against a model in the bench that holds the sampled command history of each leg.

// File: rtl/tld_pkg.sv
package tld_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_gate_t;

  function automatic int cnt_width(input int delay);
    return (delay < 1) ? 1 : $clog2(delay + 1);
  endfunction

endpackage

// File: rtl/tld_sync.sv
module tld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_next_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= 1'b0;
          else         stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= 1'b0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o      = stage_q[STAGES-1];
  // value q_o takes at the next edge, used for early edge detect
  assign q_next_o = stage_q[STAGES-2];

  initial begin
    if (STAGES < 2) $error("tld_sync needs at least two stages");
  end
endmodule

// File: rtl/tld_leg.sv
module tld_leg
  import tld_pkg::*;
#(
  parameter int DELAY = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_i,
  input  logic      cmd_next_i,
  output leg_gate_t raw_o
);
  localparam int             CW   = cnt_width(DELAY);
  localparam logic [CW-1:0]  CMAX = CW'(DELAY);

  logic [CW-1:0] cnt_q;
  logic          settled;

  // count restarts on every level change of the synchronized command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cmd_next_i != cmd_i) cnt_q <= '0;
    else if (cnt_q != CMAX)       cnt_q <= cnt_q + 1'b1;
  end

  assign settled  = (cnt_q == CMAX);
  assign raw_o.hi = cmd_i & settled;
  assign raw_o.lo = ~cmd_i & settled;

  AST_HI_OFF_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_i) |-> !raw_o.hi); // R4
  AST_LO_OFF_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_i) |-> !raw_o.lo); // R4
  AST_HI_ON_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o.hi) |-> $past(cmd_i)); // R2
  AST_LO_ON_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o.lo) |-> !$past(cmd_i)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX); // R5
endmodule

// File: rtl/tld_gate.sv
module tld_gate
  import tld_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  leg_gate_t raw_i,
  input  logic      en_all_i,
  input  logic      en_hi_i,
  input  logic      en_lo_i,
  output logic      hi_o,
  output logic      lo_o
);
  logic hi_on, lo_on;

  assign hi_on = raw_i.hi & en_hi_i & en_all_i;
  assign lo_on = raw_i.lo & en_lo_i & en_all_i;

  generate
    if (ACTIVE_LOW) begin : g_inv
      assign hi_o = ~hi_on;
      assign lo_o = ~lo_on;
    end else begin : g_pass
      assign hi_o = hi_on;
      assign lo_o = lo_on;
    end
  endgenerate
endmodule

// File: rtl/tri_leg_deadtime.sv
module tri_leg_deadtime
  import tld_pkg::*;
#(
  parameter int NUM_LEGS    = 3,
  parameter int DELAY       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_LEGS-1:0] cmd_i,
  input  logic                en_all_i,
  input  logic [NUM_LEGS-1:0] en_hi_i,
  input  logic [NUM_LEGS-1:0] en_lo_i,
  output logic [NUM_LEGS-1:0] gate_hi_o,
  output logic [NUM_LEGS-1:0] gate_lo_o
);
  localparam logic OFF_LVL = ACTIVE_LOW;

  logic [NUM_LEGS-1:0] cmd_s, cmd_s_next;
  leg_gate_t           raw [NUM_LEGS];

  generate
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      tld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .d_i      (cmd_i[g]),
        .q_o      (cmd_s[g]),
        .q_next_o (cmd_s_next[g])
      );

      tld_leg #(.DELAY(DELAY)) u_leg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cmd_i      (cmd_s[g]),
        .cmd_next_i (cmd_s_next[g]),
        .raw_o      (raw[g])
      );

      tld_gate #(.ACTIVE_LOW(ACTIVE_LOW)) u_gate (
        .raw_i    (raw[g]),
        .en_all_i (en_all_i),
        .en_hi_i  (en_hi_i[g]),
        .en_lo_i  (en_lo_i[g]),
        .hi_o     (gate_hi_o[g]),
        .lo_o     (gate_lo_o[g])
      );

      AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((gate_hi_o[g] != OFF_LVL) && (gate_lo_o[g] != OFF_LVL))); // R8
      AST_HI_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_hi_i[g] |-> gate_hi_o[g] == OFF_LVL); // R7
      AST_LO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_lo_i[g] |-> gate_lo_o[g] == OFF_LVL); // R7
    end
  endgenerate

  AST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_all_i |-> (gate_hi_o == {NUM_LEGS{OFF_LVL}}) && (gate_lo_o == {NUM_LEGS{OFF_LVL}})); // R6

  initial begin
    if (DELAY < 1) $error("DELAY must be at least one cycle");
  end
endmodule

// File: tb/tri_leg_deadtime_bench.sv
module tri_leg_deadtime_bench;
  localparam int NL = 3;
  localparam int HL = 10; // samples needed: sync + delay

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] cmd = '0;
  logic          en_all = 1'b1;
  logic [NL-1:0] en_hi = '1;
  logic [NL-1:0] en_lo = '1;
  logic [NL-1:0] gate_hi, gate_lo;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int edges = 0;
  bit finished = 1'b0;
  string tag = "R1";

  logic [HL-1:0] hist [NL];

  always #2.5 clk = ~clk;

  tri_leg_deadtime u_tri_leg_deadtime (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmd_i     (cmd),
    .en_all_i  (en_all),
    .en_hi_i   (en_hi),
    .en_lo_i   (en_lo),
    .gate_hi_o (gate_hi),
    .gate_lo_o (gate_lo)
  );

  // sampled command history, hist[l][0] = newest sample
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) hist[l] = '0;
      edges = 0;
    end else begin
      for (int l = 0; l < NL; l++) hist[l] = {hist[l][HL-2:0], cmd[l]};
      edges = edges + 1;
    end
  end

  function automatic logic exp_hi(input int l);
    return (hist[l][HL-1:1] == '1) && en_all && en_hi[l];
  endfunction

  function automatic logic exp_lo(input int l);
    return (hist[l][HL-1:1] == '0) && (edges >= 8) && en_all && en_lo[l];
  endfunction

  task automatic check(input string t, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s %s at cycle %0d: got %b expected %b", t, what, cycles, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int l = 0; l < NL; l++) begin
        check(tag, $sformatf("hi leg%0d", l), gate_hi[l], exp_hi(l));
        check(tag, $sformatf("lo leg%0d", l), gate_lo[l], exp_lo(l));
        check("R8", $sformatf("overlap leg%0d", l), gate_hi[l] & gate_lo[l], 1'b0);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    summary();
  end

  initial begin : main
    int unused;
    unused = $urandom(32'd4242);
    step(3);
    check("R1", "hi in reset", |gate_hi, 1'b0);
    check("R1", "lo in reset", |gate_lo, 1'b0);
    rst_n = 1'b1;
    check("R1", "hi after reset", |gate_hi, 1'b0);
    check("R1", "lo after reset", |gate_lo, 1'b0);
    step(12);
    check("R1", "lo on after settle", &gate_lo, 1'b1);

    tag = "R2";
    cmd[0] = 1'b1;
    step(9);
    check("R2", "hi still off at 9", gate_hi[0], 1'b0);
    step(1);
    check("R2", "hi on at 10", gate_hi[0], 1'b1);
    check("R9", "leg1 untouched", gate_lo[1], 1'b1);
    step(4);

    tag = "R4";
    cmd[0] = 1'b0;
    step(1);
    check("R4", "hi holds after 1 edge", gate_hi[0], 1'b1);
    step(1);
    check("R4", "hi off after 2 edges", gate_hi[0], 1'b0);
    tag = "R3";
    step(8);
    check("R3", "lo on at 10", gate_lo[0], 1'b1);

    tag = "R5";
    cmd[1] = 1'b1;
    step(4);
    cmd[1] = 1'b0;
    step(6);
    check("R5", "no hi from short pulse", gate_hi[1], 1'b0);
    check("R5", "lo restarted off", gate_lo[1], 1'b0);
    step(6);
    check("R5", "lo back on", gate_lo[1], 1'b1);
    cmd[2] = 1'b1;
    step(8);
    cmd[2] = 1'b0;
    step(1);
    cmd[2] = 1'b1;
    step(12);
    check("R5", "hi on after restart", gate_hi[2], 1'b1);

    tag = "R6";
    en_all = 1'b0;
    #0.5;
    check("R6", "all hi off", |gate_hi, 1'b0);
    check("R6", "all lo off", |gate_lo, 1'b0);
    step(3);
    en_all = 1'b1;
    step(2);

    tag = "R7";
    en_hi[2] = 1'b0;
    #0.5;
    check("R7", "masked hi", gate_hi[2], 1'b0);
    check("R7", "other lo kept", gate_lo[0], 1'b1);
    en_lo[0] = 1'b0;
    #0.5;
    check("R7", "masked lo", gate_lo[0], 1'b0);
    check("R7", "leg1 lo kept", gate_lo[1], 1'b1);
    step(3);
    en_hi = '1;
    en_lo = '1;

    tag = "R9";
    for (int k = 0; k < 600; k++) begin
      int l;
      l = $urandom_range(0, NL - 1);
      cmd[l] = ~cmd[l];
      if ($urandom_range(0, 15) == 0) en_hi[$urandom_range(0, NL - 1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) en_lo[$urandom_range(0, NL - 1)] ^= 1'b1;
      if ($urandom_range(0, 31) == 0) en_all = ~en_all;
      step($urandom_range(1, 20));
    end
    en_all = 1'b1;
    step(20);
    summary();
  end
endmodule